// File: doc/BRIEF.md
# Second-Order IIR Loop Compensator

This block is the discrete form of a two-pole, two-zero loop compensator. The continuous design is mapped to the z domain offline by a bilinear transform whose step is the converter's sample period. Once per sample strobe the block takes the present error e(n) and combines it with the two errors and two outputs it kept from earlier samples. Five programmable signed fixed-point coefficients weight these five terms, and the result is the control output u(n).

The sum of the five products is kept at full width. It is scaled back by the coefficients' fractional bits, and it is clamped to a programmable window before it leaves the block. The clamped value is also the one kept as output history, which keeps the loop from winding up. The present error enters the same update that produces u(n), so the block adds only one register stage of latency. A small write port loads the coefficients and the clamp window.

Top module: `iir2_comp`

## Requirements
- R1: During and after reset, u_out and u_vld are 0 and all four history values (two errors, two outputs) are 0. Coefficients reset to 0, the upper limit to the largest UW-bit signed value and the lower limit to the smallest.
- R2: On a clock edge with sample_vld high, the block computes acc = c0*e(n) + c1*e(n-1) + c2*e(n-2) + c3*u(n-1) + c4*u(n-2). The feedback terms are added, so their sign lives in the coefficients. e(n) is err_in in that same cycle.
- R3: acc is formed without overflow for any operand values. It is scaled as (acc + 2^(FRAC-1)) >>> FRAC, which is round half up, with FRAC = 14 by default.
- R4: The scaled value is clamped to [lower limit, upper limit]. The clamped value is placed on u_out and is the value stored as u(n-1).
- R5: After a sample, e(n-1) moves to e(n-2), e(n) to e(n-1), u(n-1) to u(n-2) and the new u(n) to u(n-1). Without sample_vld, u_out and the whole history are held.
- R6: u_vld is high for exactly the one cycle after each edge on which sample_vld was high. u_out changes in that same cycle.
- R7: A write with cfg_we high loads cfg_data into the register chosen by cfg_addr: 0 to 4 are coefficients c0..c4, 5 is the upper limit and 6 is the lower limit. The limits take cfg_data[UW-1:0]. A write to address 7 changes nothing.
- R8: A sample on the same edge as a coefficient write uses the value held before that edge. The new value applies from the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_data | input | CW (18) | Configuration write data |
| sample_vld | input | 1 | One-cycle strobe marking a new error sample |
| err_in | input | EW (16) | Signed error e(n) |
| u_out | output | UW (16) | Clamped signed control output u(n) |
| u_vld | output | 1 | High for one cycle when u_out is updated |

## Verification
The clamp assertion assumes the lower limit never exceeds the upper limit. It checks only when that is true for the limits held at the sample edge. The random stimulus draws the lower limit from the negative range and the upper limit from the positive range, so the window is always valid. The history and hold assertions assume that sample_vld is a plain level sampled on each edge, with no constraint on how long it stays high or low. For that reason the bench mixes single strobes, gaps of varied length and coefficient writes that fall on the strobe edge itself.

// File: rtl/iir2_pkg.sv
package iir2_pkg;
   localparam int NTAP = 5;
   // tap order: 0 e(n), 1 e(n-1), 2 e(n-2), 3 u(n-1), 4 u(n-2)
   typedef enum logic [2:0] {
      CA_C0 = 3'd0,
      CA_C1 = 3'd1,
      CA_C2 = 3'd2,
      CA_C3 = 3'd3,
      CA_C4 = 3'd4,
      CA_HI = 3'd5,
      CA_LO = 3'd6
   } cfg_addr_e;
endpackage

// File: rtl/iir2_cfg_bank.sv
module iir2_cfg_bank
   import iir2_pkg::*;
#(
   parameter int CW = 18,
   parameter int UW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [2:0]           cfg_addr,
   input  logic [CW-1:0]        cfg_data,
   output logic signed [CW-1:0] coef [NTAP],
   output logic signed [UW-1:0] lim_hi,
   output logic signed [UW-1:0] lim_lo
);
   localparam logic signed [UW-1:0] UMAX = {1'b0, {(UW-1){1'b1}}};
   localparam logic signed [UW-1:0] UMIN = {1'b1, {(UW-1){1'b0}}};

   for (genvar i = 0; i < NTAP; i++) begin : g_coef
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            coef[i] <= '0;
         else if (cfg_we && cfg_addr == 3'(i))
            coef[i] <= cfg_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_hi <= UMAX;
         lim_lo <= UMIN;
      end else if (cfg_we) begin
         if (cfg_addr == CA_HI) lim_hi <= cfg_data[UW-1:0];
         if (cfg_addr == CA_LO) lim_lo <= cfg_data[UW-1:0];
      end
   end
endmodule

// File: rtl/iir2_mac.sv
module iir2_mac
   import iir2_pkg::*;
#(
   parameter int CW = 18,
   parameter int DW = 16,
   parameter int AW = 38
) (
   input  logic signed [CW-1:0] coef [NTAP],
   input  logic signed [DW-1:0] tap  [NTAP],
   output logic signed [AW-1:0] acc
);
   localparam int PW = CW + DW;

   logic signed [PW-1:0] prod [NTAP];

   for (genvar i = 0; i < NTAP; i++) begin : g_prod
      assign prod[i] = PW'(coef[i]) * PW'(tap[i]);
   end

   always_comb begin
      acc = '0;
      for (int i = 0; i < NTAP; i++)
         acc = acc + AW'(prod[i]);
   end
endmodule

// File: rtl/iir2_scale_sat.sv
module iir2_scale_sat #(
   parameter int AW    = 38,
   parameter int FRAC  = 14,
   parameter int UW    = 16,
   parameter bit ROUND = 1'b1
) (
   input  logic signed [AW-1:0] acc,
   input  logic signed [UW-1:0] lim_hi,
   input  logic signed [UW-1:0] lim_lo,
   output logic signed [UW-1:0] y
);
   localparam int SW = AW - FRAC;

   logic signed [AW-1:0] biased;
   logic signed [SW-1:0] scaled;

   if (ROUND) begin : g_round
      localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC - 1);
      assign biased = acc + HALF;
   end else begin : g_trunc
      assign biased = acc;
   end

   assign scaled = SW'(biased >>> FRAC);

   always_comb begin
      if (scaled > SW'(lim_hi))
         y = lim_hi;
      else if (scaled < SW'(lim_lo))
         y = lim_lo;
      else
         y = UW'(scaled);
   end
endmodule

// File: rtl/iir2_hist.sv
module iir2_hist #(
   parameter int EW = 16,
   parameter int UW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 shift,
   input  logic signed [EW-1:0] e_new,
   input  logic signed [UW-1:0] u_new,
   output logic signed [EW-1:0] e_d1,
   output logic signed [EW-1:0] e_d2,
   output logic signed [UW-1:0] u_d1,
   output logic signed [UW-1:0] u_d2
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_d1 <= '0;
         e_d2 <= '0;
         u_d1 <= '0;
         u_d2 <= '0;
      end else if (shift) begin
         e_d2 <= e_d1;
         e_d1 <= e_new;
         u_d2 <= u_d1;
         u_d1 <= u_new;
      end
   end
endmodule

// File: rtl/iir2_comp.sv
module iir2_comp
   import iir2_pkg::*;
#(
   parameter int EW    = 16,
   parameter int UW    = 16,
   parameter int CW    = 18,
   parameter int FRAC  = 14,
   parameter bit ROUND = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_addr,
   input  logic [CW-1:0] cfg_data,
   input  logic          sample_vld,
   input  logic [EW-1:0] err_in,
   output logic [UW-1:0] u_out,
   output logic          u_vld
);
   localparam int DW = (EW > UW) ? EW : UW;
   localparam int AW = CW + DW + 4;

   if (EW < 2 || UW < 2)   begin : g_bad_w   $error("data widths must be at least 2"); end
   if (CW < UW)            begin : g_bad_cw  $error("CW must hold a limit value"); end
   if (FRAC < 1 || FRAC >= CW + DW) begin : g_bad_f $error("FRAC out of range"); end

   logic signed [CW-1:0] coef [NTAP];
   logic signed [UW-1:0] lim_hi, lim_lo;
   logic signed [EW-1:0] e_d1, e_d2;
   logic signed [UW-1:0] u_d1, u_d2;
   logic signed [DW-1:0] tap [NTAP];
   logic signed [AW-1:0] acc;
   logic signed [UW-1:0] u_next;

   iir2_cfg_bank #(.CW(CW), .UW(UW)) i_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_data(cfg_data), .coef(coef), .lim_hi(lim_hi), .lim_lo(lim_lo)
   );

   assign tap[0] = DW'($signed(err_in));
   assign tap[1] = DW'(e_d1);
   assign tap[2] = DW'(e_d2);
   assign tap[3] = DW'(u_d1);
   assign tap[4] = DW'(u_d2);

   iir2_mac #(.CW(CW), .DW(DW), .AW(AW)) i_mac (
      .coef(coef), .tap(tap), .acc(acc)
   );

   iir2_scale_sat #(.AW(AW), .FRAC(FRAC), .UW(UW), .ROUND(ROUND)) i_sat (
      .acc(acc), .lim_hi(lim_hi), .lim_lo(lim_lo), .y(u_next)
   );

   iir2_hist #(.EW(EW), .UW(UW)) i_hist (
      .clk(clk), .rst_n(rst_n), .shift(sample_vld),
      .e_new($signed(err_in)), .u_new(u_next),
      .e_d1(e_d1), .e_d2(e_d2), .u_d1(u_d1), .u_d2(u_d2)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) u_vld <= 1'b0;
      else        u_vld <= sample_vld;
   end

   assign u_out = u_d1;
endmodule

// File: rtl/iir2_comp_chk.sv
module iir2_comp_chk #(
   parameter int EW = 16,
   parameter int UW = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sample_vld,
   input logic [EW-1:0]        err_in,
   input logic [UW-1:0]        u_out,
   input logic                 u_vld,
   input logic signed [UW-1:0] lim_hi,
   input logic signed [UW-1:0] lim_lo,
   input logic signed [EW-1:0] e_d1,
   input logic signed [EW-1:0] e_d2,
   input logic signed [UW-1:0] u_d1,
   input logic signed [UW-1:0] u_d2
);
   assert_vld_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sample_vld |=> u_vld);

   assert_vld_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_vld |=> !u_vld);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_vld |=> ($stable(u_out) && $stable(e_d1) && $stable(e_d2) && $stable(u_d2)));

   assert_err_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sample_vld |=> (e_d1 == $signed($past(err_in)) && e_d2 == $past(e_d1)));

   assert_out_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sample_vld |=> (u_d2 == $past(u_d1)));

   assert_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (u_vld && $past(lim_lo) <= $past(lim_hi)) |->
         ($signed(u_out) <= $past(lim_hi) && $signed(u_out) >= $past(lim_lo)));
endmodule

bind iir2_comp iir2_comp_chk #(.EW(EW), .UW(UW)) i_chk (
   .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .err_in(err_in),
   .u_out(u_out), .u_vld(u_vld), .lim_hi(lim_hi), .lim_lo(lim_lo),
   .e_d1(e_d1), .e_d2(e_d2), .u_d1(u_d1), .u_d2(u_d2)
);

// File: tb/test_iir2_comp.sv
module test_iir2_comp;
   localparam int CLK_PER = 10;
   localparam int EW = 16, UW = 16, CW = 18, FRAC = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_addr = '0;
   logic [CW-1:0] cfg_data = '0;
   logic          sample_vld = 1'b0;
   logic [EW-1:0] err_in = '0;
   logic [UW-1:0] u_out;
   logic          u_vld;

   int total = 0;
   int bad = 0;

   longint mc [5];
   longint mhi, mlo, me1, me2, mu1, mu2;

   always #(CLK_PER/2) clk = ~clk;

   iir2_comp i_iir2_comp (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_data(cfg_data), .sample_vld(sample_vld), .err_in(err_in),
      .u_out(u_out), .u_vld(u_vld)
   );

   function automatic longint model_out(longint e);
      longint acc;
      acc = mc[0]*e + mc[1]*me1 + mc[2]*me2 + mc[3]*mu1 + mc[4]*mu2;
      acc = (acc + (longint'(1) <<< (FRAC-1))) >>> FRAC;
      if (acc > mhi) acc = mhi;
      if (acc < mlo) acc = mlo;
      return acc;
   endfunction

   task automatic check(string req, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 5; i++) mc[i] = 0;
      mhi = 32767; mlo = -32768;
      me1 = 0; me2 = 0; mu1 = 0; mu2 = 0;
   endtask

   // one write; model updated after the edge (R7, R8)
   task automatic cfg_write(int addr, longint val, bit with_sample, longint e, string req);
      longint y;
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_data = CW'(val);
      sample_vld = with_sample; err_in = EW'(e);
      @(negedge clk);
      cfg_we = 1'b0; sample_vld = 1'b0;
      if (with_sample) begin
         y = model_out(e);
         check(req, longint'($signed(u_out)), y);
         me2 = me1; me1 = e; mu2 = mu1; mu1 = y;
      end
      if (addr < 5) mc[addr] = longint'($signed(CW'(val)));
      else if (addr == 5) mhi = longint'($signed(UW'(val)));
      else if (addr == 6) mlo = longint'($signed(UW'(val)));
   endtask

   task automatic do_sample(longint e, string req);
      longint y;
      @(negedge clk);
      sample_vld = 1'b1; err_in = EW'(e);
      @(negedge clk);
      sample_vld = 1'b0;
      y = model_out(e);
      check(req, longint'($signed(u_out)), y);
      check("R6 u_vld", longint'(u_vld), 1);
      me2 = me1; me1 = e; mu2 = mu1; mu1 = y;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      longint hold;
      void'($urandom(32'd7321));
      model_reset();
      repeat (3) @(negedge clk);
      check("R1 u_out in reset", longint'(u_out), 0);
      check("R1 u_vld in reset", longint'(u_vld), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 u_out after reset", longint'(u_out), 0);

      // R1: reset coefficients are zero -> output 0
      do_sample(1234, "R1 zero coefs");
      // R2: pure gain, then all taps
      cfg_write(0, 16384, 0, 0, "R7");
      do_sample(1000, "R2 c0 only");
      cfg_write(1, -8192, 0, 0, "R7");
      cfg_write(2, 4096, 0, 0, "R7");
      cfg_write(3, 16384, 0, 0, "R7");
      cfg_write(4, -3000, 0, 0, "R7");
      do_sample(-2500, "R2 all taps");
      do_sample(777, "R2 all taps");
      do_sample(3, "R3 rounding");

      // R5: idle with wiggling input holds output
      hold = longint'($signed(u_out));
      for (int k = 0; k < 5; k++) begin
         @(negedge clk); err_in = EW'($urandom);
      end
      check("R5 hold u_out", longint'($signed(u_out)), hold);
      check("R6 no u_vld when idle", longint'(u_vld), 0);
      do_sample(10, "R5 history kept across gap");

      // R7: address 7 ignored
      cfg_write(7, 99999, 0, 0, "R7");
      do_sample(-55, "R7 addr7 ignored");

      // R8: write on the strobe edge uses old value
      cfg_write(0, -20000, 1, 900, "R8 old coef used");
      do_sample(900, "R8 new coef used");

      // R4: narrow clamp window
      cfg_write(5, 300, 0, 0, "R7");
      cfg_write(6, -200, 0, 0, "R7");
      do_sample(30000, "R4 clamp");
      do_sample(-30000, "R4 clamp");
      do_sample(0, "R4 stored clamped value");

      // R3: extreme operands must not wrap
      cfg_write(5, 32767, 0, 0, "R7");
      cfg_write(6, -32768, 0, 0, "R7");
      for (int i = 0; i < 5; i++) cfg_write(i, -131072, 0, 0, "R7");
      for (int k = 0; k < 4; k++) do_sample(-32768, "R3 no overflow");
      for (int i = 0; i < 5; i++) cfg_write(i, 131071, 0, 0, "R7");
      for (int k = 0; k < 3; k++) do_sample(32767, "R3 no overflow");

      // random phase
      for (int blk = 0; blk < 12; blk++) begin
         for (int i = 0; i < 5; i++)
            cfg_write(i, longint'($urandom_range(0, 40000)) - 20000, 0, 0, "R7");
         cfg_write(5, longint'($urandom_range(500, 32767)), 0, 0, "R7");
         cfg_write(6, -longint'($urandom_range(500, 32768)), 0, 0, "R7");
         for (int k = 0; k < 25; k++) begin
            int gap = int'($urandom_range(0, 3));
            repeat (gap) @(negedge clk);
            if ($urandom_range(0, 9) == 0)
               cfg_write(int'($urandom_range(0, 4)),
                         longint'($urandom_range(0, 40000)) - 20000, 1,
                         longint'($urandom_range(0, 65535)) - 32768, "R8 random");
            else
               do_sample(longint'($urandom_range(0, 65535)) - 32768, "R2 random");
         end
      end

      // R1: reset clears history
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R1 u_out cleared", longint'(u_out), 0);
      rst_n = 1'b1;
      model_reset();
      cfg_write(1, 16384, 0, 0, "R7");
      do_sample(500, "R1 history cleared");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule